// File: doc/BRIEF.md
# Fractional-Increment Realtime Counter

This block is a free-running 64-bit master count whose rate is set by a ratio of two small integers rather than by the frequency of the clock it runs on. On every enabled input clock a remainder accumulator gains the numerator. Each time that sum reaches the denominator, the denominator is taken back off and the count advances by one. The long-run count rate is therefore exactly f_in × numerator / denominator. For example, 8/25 turns a 19.2 MHz clock into 6.144 MHz. Other exact cases are 64/125 at 12 MHz, 4/25 at 38.4 MHz, 192/625 at 20 MHz, 384/1625 at 26 MHz and 256/1125 at 27 MHz. A fallback ratio of 75/244 is also accepted.

The numerator and the denominator live in two 32-bit registers behind a simple write and read port. Only the low 12 bits of each register are the ratio field, and the rest of the word is left untouched by writes. Writing either register restarts the remainder from zero, so a new ratio starts from a clean phase. A one-cycle tick marks every cycle in which the count advanced. A denominator of zero halts the count.

Top module: `frac_rate_counter`

## Requirements
- R1: After reset the count is 0, tick is 0, the numerator field reads 8 and the denominator field reads 25.
- R2: With the counter enabled and a nonzero denominator greater than the numerator, N clocks started from a cleared remainder advance the count by exactly floor(N × numerator / denominator).
- R3: The count never changes by anything other than +1 in a clock, and tick is high in exactly those cycles in which the count has just advanced.
- R4: A register write changes only bits 11:0 of the addressed register. Bits 31:12 keep their value, which is zero from reset, so writing 0xFFFFF123 to the numerator reads back as 0x00000123.
- R5: The numerator register is at address 0x10 and the denominator register is at 0x14. A write to any other address changes neither register, and a read of any other address returns 0.
- R6: A write to either ratio register clears the remainder. The count does not advance in the write cycle.
- R7: While the denominator field is 0 the count holds its value and tick stays low, even when the counter is enabled.
- R8: While the enable input is low, both the count and the remainder hold their values.
- R9: When the numerator is greater than or equal to a nonzero denominator, the count advances by one on every enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock of arbitrary frequency |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEnable | input | 1 | Lets the counter advance when high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| count | output | 64 | Free-running master count |
| tick | output | 1 | High for one cycle after each count advance |

## Verification
A register write is captured at the rising edge on which it is presented, and its value is visible on the combinational read port from then on. The count and tick both change at the rising edge where an accumulator step happens, so each of them is due in the same cycle as the step that causes it. The bench moves inputs on falling edges and samples outputs on the following falling edge. A run of N enabled cycles is therefore exactly N rising edges, and every expected count is a closed-form floor of N × numerator / denominator added to the count read just before the run.

// File: rtl/frac_cnt_pkg.sv
package frac_cnt_pkg;
  // Strobes from the control side to the accumulator datapath
  typedef struct packed {
    logic clrPhase;  // restart remainder at zero, no advance this cycle
    logic advance;   // perform one accumulator step
  } stepCtrl_t;
endpackage

// File: rtl/frac_cnt_ctrl.sv
module frac_cnt_ctrl
  import frac_cnt_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int FIELD_W   = 12,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] NUM_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_ADDR = 8'h14,
  parameter int NUM_RESET = 8,
  parameter int DEN_RESET = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntEnable,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic [FIELD_W-1:0] numVal,
  output logic [FIELD_W-1:0] denVal,
  output stepCtrl_t          stepCtrl
);
  localparam int NREGS = 2;
  localparam logic [ADDR_W-1:0] REG_ADDRS [NREGS] = '{NUM_ADDR, DEN_ADDR};
  localparam logic [FIELD_W-1:0] REG_RESETS [NREGS] =
    '{FIELD_W'(NUM_RESET), FIELD_W'(DEN_RESET)};

  logic [REG_W-1:0] regFile [NREGS];
  logic [NREGS-1:0] hit;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    assign hit[i] = (regAddr == REG_ADDRS[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFile[i] <= {{(REG_W-FIELD_W){1'b0}}, REG_RESETS[i]};
      end else if (regWrEn && hit[i]) begin
        regFile[i] <= {regFile[i][REG_W-1:FIELD_W], regWrData[FIELD_W-1:0]};
      end
    end

    // R4: a write lands in the low field and leaves the upper bits alone
    p_field_write_r4: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && hit[i]) |=>
        (regFile[i][FIELD_W-1:0] == $past(regWrData[FIELD_W-1:0])) &&
        (regFile[i][REG_W-1:FIELD_W] == $past(regFile[i][REG_W-1:FIELD_W])));

    // R5: nothing but a matching write alters the register
    p_no_stray_write_r5: assert property (@(posedge clk) disable iff (!rstN)
      !(regWrEn && hit[i]) |=> $stable(regFile[i]));
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (hit[i]) regRdData = regFile[i];
    end
  end

  assign numVal = regFile[0][FIELD_W-1:0];
  assign denVal = regFile[1][FIELD_W-1:0];

  logic anyWrite;
  assign anyWrite = regWrEn && (|hit);

  always_comb begin
    stepCtrl.clrPhase = anyWrite;
    stepCtrl.advance  = cntEnable && !anyWrite && (denVal != '0);
  end

  // R7: a zero denominator never requests a step
  p_halt_no_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (denVal == '0) |-> !stepCtrl.advance);
endmodule

// File: rtl/frac_cnt_datapath.sv
module frac_cnt_datapath
  import frac_cnt_pkg::*;
#(
  parameter int FIELD_W = 12,
  parameter int COUNT_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] numVal,
  input  logic [FIELD_W-1:0] denVal,
  input  stepCtrl_t          stepCtrl,
  output logic [COUNT_W-1:0] count,
  output logic               tick
);
  logic [FIELD_W-1:0] acc;
  logic [FIELD_W:0]   sumWide;
  logic [FIELD_W-1:0] wrapRem;
  logic               ratioFull;
  logic               carry;

  assign sumWide   = {1'b0, acc} + {1'b0, numVal};
  assign wrapRem   = acc + numVal - denVal;   // valid when a carry happens
  assign ratioFull = (numVal >= denVal);
  assign carry     = ratioFull || (sumWide >= {1'b0, denVal});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      count <= '0;
      tick  <= 1'b0;
    end else if (stepCtrl.clrPhase) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (stepCtrl.advance) begin
      if (ratioFull) begin
        acc <= '0;
      end else if (carry) begin
        acc <= wrapRem;
      end else begin
        acc <= sumWide[FIELD_W-1:0];
      end
      if (carry) count <= count + COUNT_W'(1);
      tick <= carry;
    end else begin
      tick <= 1'b0;
    end
  end

  // R3: count only ever steps by one
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == $past(count) + COUNT_W'(1)));

  // R3: tick flags exactly the cycles that advanced
  p_tick_marks_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    tick == (count != $past(count)));

  // R6: a ratio write restarts the remainder
  p_phase_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    stepCtrl.clrPhase |=> (acc == '0) && $stable(count));

  // R8: no step request, nothing moves
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stepCtrl.advance |=> $stable(count) && !tick);

  // R2: remainder stays below a nonzero denominator
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (denVal != '0) |-> (acc < denVal));
endmodule

// File: rtl/frac_rate_counter.sv
module frac_rate_counter
  import frac_cnt_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int FIELD_W   = 12,
  parameter int ADDR_W    = 8,
  parameter int COUNT_W   = 64,
  parameter int NUM_RESET = 8,
  parameter int DEN_RESET = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntEnable,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic [COUNT_W-1:0] count,
  output logic               tick
);
  logic [FIELD_W-1:0] numVal;
  logic [FIELD_W-1:0] denVal;
  stepCtrl_t          stepCtrl;

  frac_cnt_ctrl #(
    .REG_W(REG_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W),
    .NUM_ADDR(ADDR_W'(8'h10)), .DEN_ADDR(ADDR_W'(8'h14)),
    .NUM_RESET(NUM_RESET), .DEN_RESET(DEN_RESET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .numVal(numVal), .denVal(denVal),
    .stepCtrl(stepCtrl)
  );

  frac_cnt_datapath #(
    .FIELD_W(FIELD_W), .COUNT_W(COUNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .numVal(numVal), .denVal(denVal),
    .stepCtrl(stepCtrl), .count(count), .tick(tick)
  );
endmodule

// File: tb/frac_rate_counter_bench.sv
module frac_rate_counter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEnable = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] count;
  logic        tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frac_rate_counter u_frac_rate_counter (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .count(count), .tick(tick)
  );

  // numerator, denominator, cycles, expected advance (R2)
  localparam int NVEC = 7;
  localparam int VEC [NVEC][4] = '{
    '{8,   25,   100,  32},
    '{64,  125,  250,  128},
    '{4,   25,   50,   8},
    '{75,  244,  244,  75},
    '{384, 1625, 1625, 384},
    '{192, 625,  100,  30},
    '{256, 1125, 300,  68}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic runCycles(int n);
    @(negedge clk);
    cntEnable = 1'b1;
    repeat (n) @(negedge clk);
    cntEnable = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    check("R1 count", count, 64'd0);
    check("R1 tick", {63'd0, tick}, 64'd0);
    readReg(8'h10, rd); check("R1 num", {32'd0, rd}, 64'd8);
    readReg(8'h14, rd); check("R1 den", {32'd0, rd}, 64'd25);

    // R2 rate vectors (upper junk in writes also exercises R4)
    for (int v = 0; v < NVEC; v++) begin
      writeReg(8'h10, 32'hABCDE000 | 32'(VEC[v][0]));
      writeReg(8'h14, 32'h55555000 | 32'(VEC[v][1]));
      base = count;
      runCycles(VEC[v][2]);
      check($sformatf("R2 ratio %0d/%0d", VEC[v][0], VEC[v][1]),
            count - base, 64'(VEC[v][3]));
    end
    readReg(8'h14, rd); check("R4 den upper kept zero", {32'd0, rd}, 64'd1125);

    // R4 field masking
    writeReg(8'h10, 32'hFFFFF123);
    readReg(8'h10, rd); check("R4 num mask", {32'd0, rd}, 64'h123);

    // R5 unmapped address
    writeReg(8'h18, 32'h00000777);
    readReg(8'h10, rd); check("R5 num untouched", {32'd0, rd}, 64'h123);
    readReg(8'h14, rd); check("R5 den untouched", {32'd0, rd}, 64'd1125);
    readReg(8'h18, rd); check("R5 unmapped read", {32'd0, rd}, 64'd0);

    // R3 tick pattern at ratio 1/2
    writeReg(8'h10, 32'd1);
    writeReg(8'h14, 32'd2);
    base = count;
    @(negedge clk);
    cntEnable = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check($sformatf("R3 tick cycle %0d", k), {63'd0, tick}, 64'(k % 2));
    end
    cntEnable = 1'b0;
    check("R3 count after 4", count - base, 64'd2);

    // R6 write clears remainder
    writeReg(8'h14, 32'd2);
    base = count;
    runCycles(1);
    writeReg(8'h10, 32'd1);
    runCycles(1);
    check("R6 no carry after clear", count - base, 64'd0);
    runCycles(1);
    check("R6 carry on second step", count - base, 64'd1);

    // R8 enable low holds count and remainder
    writeReg(8'h14, 32'd2);
    base = count;
    runCycles(1);
    repeat (10) @(negedge clk);
    check("R8 count held", count - base, 64'd0);
    runCycles(1);
    check("R8 remainder kept", count - base, 64'd1);

    // R7 zero denominator halts
    writeReg(8'h14, 32'd0);
    base = count;
    @(negedge clk);
    cntEnable = 1'b1;
    repeat (20) @(negedge clk);
    check("R7 tick low", {63'd0, tick}, 64'd0);
    cntEnable = 1'b0;
    check("R7 count held", count - base, 64'd0);

    // R9 numerator not below denominator
    writeReg(8'h10, 32'd5);
    writeReg(8'h14, 32'd3);
    base = count;
    runCycles(10);
    check("R9 one per clock", count - base, 64'd10);
    writeReg(8'h10, 32'd3);
    base = count;
    runCycles(7);
    check("R9 equal ratio", count - base, 64'd7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule